// File: doc/BRIEF.md
# TDM Frame Slot Access Unit

The unit sits on a serial time-division frame bus: a frame sync pulse, a bit-rate data clock, an upstream line and a downstream line. Every frame carries twelve byte-wide slots, with two clocks per bit and the most significant bit first. Four byte channels, grouped as two pairs (an even member and an odd member in each pair), give a host access to that traffic. Each channel picks one slot and one line to capture from. It can drive a byte back onto the opposite line in the same slot position. It can also take its byte from its pair partner, which moves data between slots.

Typical uses are looping a slot back toward its source one frame later, moving a byte from slot a to slot b, monitoring slots on both lines at once, and watching the arbitration slot (slot 11). Each channel can raise a transfer interrupt at the end of its slot. When the host leaves that interrupt unacknowledged until the slot comes round again, the channel raises an overflow interrupt. The lines are open-drain: a channel that does not drive leaves the line high.

Top module: `tdm_slot_access`

## Requirements
- R1: After reset every data byte, channel setting, pair control bit and status bit is 0, irq_o is low and both line outputs stay high through whole frames.
- R2: The clock after fsc_i is high is the first clock of slot 0. A slot lasts 16 clocks and a bit 2 clocks, most significant bit first. An input bit is sampled at the clock edge that ends its second clock. Without fsc_i the count wraps every 192 clocks.
- R3: Channel setting byte (addresses 4 to 7) fields: bits 3:0 slot, bit 4 line select, bit 5 partner swap, bit 6 output enable, bit 7 interrupt enable. Line select 0 captures the upstream line and drives downstream; line select 1 does the reverse. After its slot ends, a channel's captured byte reads back at addresses 0 to 3.
- R4: With swap 0 and output enabled, the byte captured in slot s appears on the opposite line in slot s of the next frame.
- R5: With swap 1, a channel drives its partner's byte (channel index XOR 1). If its slot b is at least the partner's slot a plus 2, the byte captured in slot a goes out in slot b of the same frame.
- R6: With swap 1 and b below a+2 (b = a+1 included), slot b carries the byte the partner captured one frame earlier.
- R7: A channel whose output enable is 0 never pulls a line low.
- R8: Two channels can monitor the same frame on different lines at once, each holding its own byte.
- R9: Setting bit p of the pair control byte (address 8) makes the even channel of pair p capture upstream slot 11 regardless of its slot field, and that channel then drives nothing.
- R10: At the end of its slot, a channel with interrupt enable 1 sets its transfer bit in the status byte (address 9: bits 3:0 transfer, bits 7:4 overflow) and irq_o rises. With the enable at 0 the bit stays 0.
- R11: If the transfer bit is still set when the same channel's slot ends again, its overflow bit is set.
- R12: Reading the status byte clears all its bits. Writing 1 to bit i at address 10 clears transfer bit i, so the next transfer raises no overflow.
- R13: A host write to a data byte, made before the load point one slot ahead of the channel's slot, goes out in that slot of the same frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Data clock, two cycles per bit |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fsc_i | input | 1 | Frame sync; the next clock starts slot 0 |
| du_i | input | 1 | Upstream line as seen on the bus |
| dd_i | input | 1 | Downstream line as seen on the bus |
| du_o | output | 1 | Upstream line drive, 1 = released |
| dd_o | output | 1 | Downstream line drive, 1 = released |
| addr_i | input | 4 | Register address |
| we_i | input | 1 | Register write strobe |
| re_i | input | 1 | Register read strobe (clears status) |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data, combinational |
| irq_o | output | 1 | Any transfer or overflow bit set |

## Verification
The checks that run on every cycle cover several rules. The frame counter must realign on sync and wrap after slot 11. An overflow may only follow a pending transfer bit, and a transfer bit may only rise while its interrupt is enabled. An acknowledge must clear the bit, a status read must empty the status, and a disabled or arbitration-watching channel must release both lines. The bench scenarios cover behaviour across frames: which frame a looped or moved byte lands in, given the slot distance, two-line monitoring, the arbitration-slot override, and a host byte reaching the line.

// File: rtl/tsa_pkg.sv
package tsa_pkg;
  localparam int NSLOT        = 12;
  localparam int SLOT_BITS    = 8;
  localparam int CLK_PER_BIT  = 2;
  localparam int NREG         = 4;
  localparam int NPAIR        = NREG / 2;
  localparam int DW           = SLOT_BITS;
  localparam int AW           = 4;
  localparam int SLOT_W       = $clog2(NSLOT);
  localparam int BIT_W        = $clog2(SLOT_BITS);
  localparam int PH_W         = $clog2(CLK_PER_BIT);
  localparam int POS_W        = BIT_W + PH_W;
  localparam int CLK_PER_SLOT = SLOT_BITS * CLK_PER_BIT;
  localparam int TIC_SLOT     = NSLOT - 1;
  localparam int A_DATA0      = 0;
  localparam int A_CFG0       = NREG;
  localparam int A_CTRL       = 2 * NREG;
  localparam int A_STAT       = 2 * NREG + 1;
  localparam int A_ACK        = 2 * NREG + 2;

  typedef logic [DW-1:0] data_t;

  typedef struct packed {
    logic              irq_en;
    logic              oe;
    logic              swap;
    logic              dps;
    logic [SLOT_W-1:0] slot;
  } cfg_t;
endpackage

// File: rtl/tsa_frame_ctr.sv
module tsa_frame_ctr
  import tsa_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fsc_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic [BIT_W-1:0]  bit_o,
  output logic              slot_first_o,
  output logic              slot_last_o,
  output logic              sample_o
);
  logic [POS_W-1:0]  pos_q;
  logic [SLOT_W-1:0] slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q  <= '0;
      slot_q <= '0;
    end else if (fsc_i) begin
      pos_q  <= '0;
      slot_q <= '0;
    end else if (slot_last_o) begin
      pos_q  <= '0;
      slot_q <= (slot_q == SLOT_W'(NSLOT - 1)) ? '0 : slot_q + SLOT_W'(1);
    end else begin
      pos_q  <= pos_q + POS_W'(1);
    end
  end

  assign slot_o       = slot_q;
  assign bit_o        = pos_q[POS_W-1 -: BIT_W];
  assign slot_first_o = (pos_q == '0);
  assign slot_last_o  = (pos_q == POS_W'(CLK_PER_SLOT - 1));
  assign sample_o     = &pos_q[PH_W-1:0];

  AST_FSC_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fsc_i |=> (slot_q == '0 && pos_q == '0)); // R2
  AST_SLOT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fsc_i && slot_last_o && slot_q == SLOT_W'(NSLOT - 1)) |=> slot_q == '0); // R2
endmodule

// File: rtl/tsa_chan.sv
module tsa_chan
  import tsa_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cfg_t              cfg_i,
  input  logic              tic_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [BIT_W-1:0]  bit_i,
  input  logic              slot_first_i,
  input  logic              slot_last_i,
  input  logic              sample_i,
  input  logic              du_i,
  input  logic              dd_i,
  input  logic              wr_i,
  input  data_t             wdata_i,
  input  data_t             partner_i,
  input  logic              ack_i,
  input  logic              rd_clr_i,
  output data_t             data_o,
  output logic              du_o,
  output logic              dd_o,
  output logic              sti_o,
  output logic              stov_o
);
  data_t             shift_q, data_q, hold_q;
  logic              sti_q, stov_q, sti_n, stov_n;
  logic [SLOT_W-1:0] eff_slot, pre_slot;
  logic              in_bit, hit, load, xfer, drive, tx_bit;

  // arbitration-slot watch overrides slot and line, never drives
  assign eff_slot = tic_i ? SLOT_W'(TIC_SLOT) : cfg_i.slot;
  assign in_bit   = (!tic_i && cfg_i.dps) ? dd_i : du_i;
  assign hit      = (slot_i == eff_slot);
  assign xfer     = hit && slot_last_i;
  // output byte is fetched at the start of the slot before the driven one
  assign pre_slot = (cfg_i.slot == '0) ? SLOT_W'(NSLOT - 1) : cfg_i.slot - SLOT_W'(1);
  assign load     = slot_first_i && (slot_i == pre_slot);
  assign drive    = cfg_i.oe && !tic_i && (slot_i == cfg_i.slot);
  assign tx_bit   = hold_q[BIT_W'(SLOT_BITS - 1) - bit_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= '0;
      data_q  <= '0;
      hold_q  <= '0;
    end else begin
      if (hit && sample_i) shift_q <= {shift_q[DW-2:0], in_bit};
      if (xfer)            data_q  <= {shift_q[DW-2:0], in_bit};
      else if (wr_i)       data_q  <= wdata_i;
      if (load)            hold_q  <= cfg_i.swap ? partner_i : data_q;
    end
  end

  always_comb begin
    sti_n  = sti_q;
    stov_n = stov_q;
    if (rd_clr_i) begin
      sti_n  = 1'b0;
      stov_n = 1'b0;
    end
    if (ack_i) sti_n = 1'b0;
    if (xfer && cfg_i.irq_en) begin
      if (sti_n) stov_n = 1'b1;
      sti_n = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sti_q  <= 1'b0;
      stov_q <= 1'b0;
    end else begin
      sti_q  <= sti_n;
      stov_q <= stov_n;
    end
  end

  assign data_o = data_q;
  assign du_o   = !(drive && cfg_i.dps) || tx_bit;
  assign dd_o   = !(drive && !cfg_i.dps) || tx_bit;
  assign sti_o  = sti_q;
  assign stov_o = stov_q;

  AST_OVF_AFTER_STI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stov_o) |-> $past(sti_o)); // R11
  AST_STI_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sti_o) |-> $past(cfg_i.irq_en)); // R10
  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !(xfer && cfg_i.irq_en)) |=> !sti_o); // R12
  AST_IDLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_i.oe || tic_i) |-> (du_o && dd_o)); // R7
endmodule

// File: rtl/tdm_slot_access.sv
module tdm_slot_access
  import tsa_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fsc_i,
  input  logic          du_i,
  input  logic          dd_i,
  output logic          du_o,
  output logic          dd_o,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o
);
  logic [SLOT_W-1:0] slot;
  logic [BIT_W-1:0]  bit_idx;
  logic              slot_first, slot_last, sample, rd_clr;
  cfg_t              cfg_q [NREG];
  logic [NPAIR-1:0]  tic_q;
  data_t             data [NREG];
  logic [NREG-1:0]   du_v, dd_v, sti, stov;

  tsa_frame_ctr i_frame_ctr (
    .clk_i, .rst_ni, .fsc_i,
    .slot_o(slot), .bit_o(bit_idx), .slot_first_o(slot_first),
    .slot_last_o(slot_last), .sample_o(sample)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) cfg_q[i] <= '0;
      tic_q <= '0;
    end else if (we_i) begin
      for (int i = 0; i < NREG; i++)
        if (addr_i == AW'(A_CFG0 + i)) cfg_q[i] <= cfg_t'(wdata_i);
      if (addr_i == AW'(A_CTRL)) tic_q <= wdata_i[NPAIR-1:0];
    end
  end

  assign rd_clr = re_i && (addr_i == AW'(A_STAT));

  for (genvar g = 0; g < NREG; g++) begin : g_chan
    logic tic;
    if (g % 2 == 0) begin : g_even
      assign tic = tic_q[g/2];
    end else begin : g_odd
      assign tic = 1'b0;
    end

    tsa_chan i_chan (
      .clk_i, .rst_ni,
      .cfg_i(cfg_q[g]), .tic_i(tic),
      .slot_i(slot), .bit_i(bit_idx), .slot_first_i(slot_first),
      .slot_last_i(slot_last), .sample_i(sample),
      .du_i, .dd_i,
      .wr_i(we_i && addr_i == AW'(A_DATA0 + g)), .wdata_i,
      .partner_i(data[g ^ 1]),
      .ack_i(we_i && addr_i == AW'(A_ACK) && wdata_i[g]),
      .rd_clr_i(rd_clr),
      .data_o(data[g]), .du_o(du_v[g]), .dd_o(dd_v[g]),
      .sti_o(sti[g]), .stov_o(stov[g])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NREG; i++) begin
      if (addr_i == AW'(A_DATA0 + i)) rdata_o = data[i];
      if (addr_i == AW'(A_CFG0 + i))  rdata_o = cfg_q[i];
    end
    if (addr_i == AW'(A_CTRL)) rdata_o = DW'(tic_q);
    if (addr_i == AW'(A_STAT)) rdata_o = DW'({stov, sti});
  end

  // open-drain: any channel pulling low wins
  assign du_o  = &du_v;
  assign dd_o  = &dd_v;
  assign irq_o = |{stov, sti};

  AST_RD_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr && !slot_last) |=> (sti == '0 && stov == '0)); // R12
endmodule

// File: tb/test_tdm_slot_access.sv
`timescale 1ns/1ps
module test_tdm_slot_access;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       fsc_i = 1'b0, du_i = 1'b1, dd_i = 1'b1;
  logic       du_o, dd_o, we_i = 1'b0, re_i = 1'b0, irq_o;
  logic [3:0] addr_i = '0;
  logic [7:0] wdata_i = '0, rdata_o;

  tdm_slot_access i_tdm_slot_access (.*);

  always #2 clk_i = ~clk_i;

  typedef struct {
    int         fr;
    bit         line;   // 0 upstream, 1 downstream
    int         slot;
    logic [7:0] val;
    string      tag;
  } exp_t;

  exp_t       q[$];
  int         n_cmp = 0, n_bad = 0, frame_no = 0, cyc = 0;
  logic [7:0] seen_du [12], seen_dd [12];
  event       frame_done;

  function automatic logic [7:0] pat_du(int fr, int s);
    return 8'(fr * 37 + s * 11 + 8'h5A);
  endfunction
  function automatic logic [7:0] pat_dd(int fr, int s);
    return 8'(fr * 53 + s * 29 + 8'hC3);
  endfunction

  task automatic push(int fr, bit line, int slot, logic [7:0] v, string tag);
    exp_t e;
    e.fr = fr; e.line = line; e.slot = slot; e.val = v; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  // driver of the frame bus and scoreboard monitor
  initial begin
    @(posedge rst_ni);
    forever begin
      int c, s, b;
      c = cyc % 192; s = c / 16; b = (c % 16) / 2;
      du_i  = pat_du(frame_no, s)[7-b];
      dd_i  = pat_dd(frame_no, s)[7-b];
      fsc_i = (c == 191);
      seen_du[s][7-b] = du_o;
      seen_dd[s][7-b] = dd_o;
      if (c == 191) begin
        while (q.size() > 0 && q[0].fr == frame_no) begin
          exp_t e;
          e = q.pop_front();
          check($sformatf("%s frame %0d %s slot %0d", e.tag, e.fr,
                          e.line ? "down" : "up", e.slot),
                e.line ? seen_dd[e.slot] : seen_du[e.slot], e.val);
        end
        frame_no++;
        -> frame_done;
      end
      cyc++;
      @(negedge clk_i);
    end
  end

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(posedge clk_i);
    #1 we_i = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d, output logic irq);
    @(negedge clk_i);
    addr_i = a; re_i = 1'b1;
    #1 d = rdata_o; irq = irq_o;
    @(posedge clk_i);
    #1 re_i = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: run hung, got timeout expected finish");
    summary();
  end

  initial begin
    logic [7:0] d;
    logic       irq;
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    rd(4'd0, d, irq);  check("R1 data0", d, 8'h00);
    rd(4'd9, d, irq);  check("R1 status", d, 8'h00);
    check("R1 irq", {7'b0, irq}, 8'h00);
    rd(4'd5, d, irq);  check("R1 cfg1", d, 8'h00);
    for (int s = 0; s < 12; s++) begin
      push(0, 1'b0, s, 8'hFF, "R1");
      push(0, 1'b1, s, 8'hFF, "R1");
    end
    @(frame_done);

    // frame 1: loop, same-frame move, monitor, next-frame move
    wr(4'd4, 8'h43);   // ch0 slot3 up->down loop
    wr(4'd5, 8'h67);   // ch1 slot7 partner, drives down
    wr(4'd6, 8'h15);   // ch2 slot5 monitor down line
    wr(4'd7, 8'h71);   // ch3 slot1 partner, drives up
    push(3, 1'b0, 0, 8'hFF, "R7 idle");
    push(3, 1'b0, 1, pat_dd(2, 5), "R6 b<a");
    push(3, 1'b1, 3, pat_du(2, 3), "R4 loop");
    push(3, 1'b1, 5, 8'hFF, "R7 oe off");
    push(3, 1'b1, 7, pat_du(3, 3), "R5 R2 same frame");
    repeat (3) @(frame_done);
    rd(4'd0, d, irq);  check("R3 capture up", d, pat_du(3, 3));
    rd(4'd2, d, irq);  check("R8 monitor down", d, pat_dd(3, 5));
    rd(4'd9, d, irq);  check("R10 disabled", d, 8'h00);
    rd(4'd5, d, irq);  check("R3 cfg readback", d, 8'h67);

    // frame 4: b = a+1, loop on the up line
    wr(4'd5, 8'h64);
    wr(4'd7, 8'h56);
    push(6, 1'b0, 1, 8'hFF, "R7 moved");
    push(6, 1'b0, 6, pat_dd(5, 6), "R4 loop up");
    push(6, 1'b1, 4, pat_du(5, 3), "R6 b=a+1");
    push(6, 1'b1, 7, 8'hFF, "R7 moved");
    repeat (3) @(frame_done);
    wr(4'd3, 8'h5A);
    push(7, 1'b0, 6, 8'h5A, "R13 host byte");
    push(8, 1'b0, 6, pat_dd(7, 6), "R13 recapture");
    repeat (2) @(frame_done);

    // frame 9: arbitration slot watch on pair 1
    wr(4'd8, 8'h02);
    wr(4'd6, 8'h55);
    push(10, 1'b0, 5, 8'hFF, "R9 no drive");
    push(10, 1'b0, 11, 8'hFF, "R9 no drive");
    repeat (2) @(frame_done);
    rd(4'd2, d, irq);  check("R9 slot11 capture", d, pat_du(10, 11));
    rd(4'd8, d, irq);  check("R9 ctrl readback", d, 8'h02);
    wr(4'd8, 8'h00);
    wr(4'd6, 8'h00);

    // frame 11: interrupts on ch0
    wr(4'd4, 8'hC3);
    @(frame_done);
    rd(4'd9, d, irq);
    check("R10 irq", {7'b0, irq}, 8'h01);
    check("R10 transfer bit", d, 8'h01);
    rd(4'd9, d, irq);
    check("R12 read clears", d, 8'h00);
    check("R12 irq low", {7'b0, irq}, 8'h00);
    repeat (2) @(frame_done);
    rd(4'd9, d, irq);  check("R11 overflow", d, 8'h11);
    @(frame_done);
    wr(4'd10, 8'h01);
    @(frame_done);
    rd(4'd9, d, irq);  check("R12 ack no overflow", d, 8'h01);

    n_cmp++;
    if (q.size() != 0) begin
      n_bad++;
      $display("FAIL scoreboard: got %0d pending expected 0", q.size());
    end
    summary();
  end
endmodule